// File: doc/BRIEF.md
# Block-Transfer DMA Channel

This block is a single DMA channel that copies data between two independent 24-bit address spaces through a bus master port. Each unit of data is moved as a read cycle at the source address followed by a write cycle at the destination address. A unit is one byte or one 16-bit word. Both addresses can step up, step down or stay fixed, by 1 for bytes or 2 for words.

In normal mode the channel runs in one of two ways. With auto-request, the channel starts by itself and keeps running until its transfer count is used up. It can hold the bus for the whole run (burst) or give the bus back after every unit (cycle-steal). Without auto-request, each pulse on the selected trigger line moves one unit. In block mode each pulse on the selected trigger line moves a whole block of 1 to 2^BW-1 units back to back. One side, source or destination, acts as a fixed block area: its address returns to the start of the block after every block, while the other side keeps advancing. The transfer counter then counts blocks.

Software loads the whole setup in one `cfg_we` cycle, and that load also enables the channel. A load is accepted only while the channel is idle. When the count runs out, `busy` drops and `irq` pulses for one cycle if interrupts were enabled.

Top module: `dma_block_channel`

## Requirements
- R1: After reset, bus_req, bus_rd, bus_wr, busy and irq are all low.
- R2: Each unit is one bus_rd cycle at the source address, followed in the next cycle by one bus_wr cycle at the destination address. The write carries the data sampled during the read. Neither cycle occurs unless bus_req and bus_gnt are both high.
- R3: The step code is 0 for fixed, 1 for increment and 2 for decrement. The step size is 1 when cfg_word is 0 and 2 when it is 1. Arithmetic wraps modulo 2^AW.
- R4: When cfg_block=0, cfg_auto=1 and cfg_burst=1, the channel runs all of its transfers with no trigger. bus_req stays high without a break from the first read to the last write.
- R5: When cfg_block=0, cfg_auto=1 and cfg_burst=0, bus_req goes low for at least one cycle after every write. bus_req therefore rises once per unit.
- R6: When cfg_block=0 and cfg_auto=0, each pulse on trig_in[cfg_trig] moves exactly one unit. Pulses on any other trig_in line move nothing.
- R7: A cfg_count of 0 means 2^CW transfers (or blocks).
- R8: When cfg_block=1, each pulse on the selected trigger line moves exactly cfg_blk units, and bus_req stays high across the whole block. Pulses on unselected lines move nothing.
- R9: In block mode, when cfg_fix_dst=0 the source side is the fixed block area, and when cfg_fix_dst=1 the destination side is. After each block, the fixed side's address returns to its loaded start value. The other side continues from where it stopped.
- R10: When the last transfer or block completes, busy goes low. irq is high for exactly one cycle at the same time, and only if cfg_ie was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load the setup and enable the channel (ignored while busy) |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_count | input | CW | Transfer or block count (0 means 2^CW) |
| cfg_blk | input | BW | Units per block (1 or more) |
| cfg_block | input | 1 | 1 selects block mode |
| cfg_auto | input | 1 | Normal mode auto-request |
| cfg_burst | input | 1 | Auto-request holds the bus for the whole run |
| cfg_word | input | 1 | 1 selects 16-bit units |
| cfg_src_step | input | 2 | Source step code |
| cfg_dst_step | input | 2 | Destination step code |
| cfg_fix_dst | input | 1 | Block mode fixed area is the destination side |
| cfg_ie | input | 1 | End interrupt enable |
| cfg_trig | input | SW | Index of the request line in use |
| trig_in | input | NTRIG | Request pulses (timers 0 to 2, converter end, external) |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_rd | output | 1 | Read cycle |
| bus_wr | output | 1 | Write cycle |
| bus_word | output | 1 | Unit is a word |
| bus_addr | output | AW | Cycle address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, sampled at the end of a read cycle |
| busy | output | 1 | Channel enabled |
| irq | output | 1 | End interrupt pulse |

## Verification
A wrong address counter or a missed rewind shows up on bus_addr at the very next read or write of the affected side. It is therefore visible within one block or one unit. A wrong count or block length changes the number of bus_wr cycles and the cycle in which busy and irq drop. This is seen when the run ends or when a block stops early or runs long. A wrong hold or release decision shows as an extra or missing rising edge of bus_req within a few cycles of a write.

// File: rtl/dma_pkg.sv
package dma_pkg;
   typedef enum logic [1:0] {
      STEP_FIX = 2'd0,
      STEP_INC = 2'd1,
      STEP_DEC = 2'd2
   } step_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_REQ  = 3'd1,
      ST_RD   = 3'd2,
      ST_WR   = 3'd3,
      ST_GAP  = 3'd4
   } state_e;
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
   parameter int AW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic [1:0]    step,
   input  logic          word,
   input  logic          adv,
   input  logic          rewind,
   output logic [AW-1:0] addr
);
   import dma_pkg::*;

   if (AW < 2) begin : g_bad_aw
      $error("dma_addr_unit: AW must be at least 2");
   end

   logic [AW-1:0] start_q;
   logic [AW-1:0] inc;

   assign inc = word ? AW'(2) : AW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr    <= '0;
         start_q <= '0;
      end else if (load) begin
         addr    <= load_val;
         start_q <= load_val;
      end else if (rewind) begin
         addr <= start_q;
      end else if (adv) begin
         case (step)
            STEP_INC: addr <= addr + inc;
            STEP_DEC: addr <= addr - inc;
            default:  addr <= addr;
         endcase
      end
   end

   // R3: a fixed side never moves on an advance
   assert_fixed_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && !rewind && step == STEP_FIX) |=> $stable(addr));
   // R9: a rewind lands on the loaded start
   assert_rewind_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rewind && !load) |=> (addr == $past(start_q)));
endmodule

// File: rtl/dma_dcount.sv
module dma_dcount #(
   parameter int W      = 16,
   parameter bit RELOAD = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   input  logic         reload,
   output logic [W-1:0] cnt,
   output logic         last
);
   if (W < 1) begin : g_bad_w
      $error("dma_dcount: W must be at least 1");
   end

   assign last = (cnt == W'(1));

   if (RELOAD) begin : g_reload
      logic [W-1:0] saved_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt     <= '0;
            saved_q <= '0;
         end else if (load) begin
            cnt     <= load_val;
            saved_q <= load_val;
         end else if (reload) begin
            cnt <= saved_q;
         end else if (dec) begin
            cnt <= cnt - W'(1);
         end
      end
   end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= '0;
         end else if (load) begin
            cnt <= load_val;
         end else if (dec) begin
            cnt <= cnt - W'(1);
         end
      end
   end
endmodule

// File: rtl/dma_trig_pick.sv
module dma_trig_pick #(
   parameter int NTRIG = 5,
   localparam int SW   = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NTRIG-1:0] trig_in,
   input  logic [SW-1:0]    sel,
   input  logic             arm,
   input  logic             clear,
   output logic             pending
);
   if (NTRIG < 1) begin : g_bad_n
      $error("dma_trig_pick: NTRIG must be at least 1");
   end

   logic hit;

   if (NTRIG == 1) begin : g_single
      assign hit = arm & trig_in[0];
   end else begin : g_mux
      assign hit = arm & (int'(sel) < NTRIG) & trig_in[sel];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pending <= 1'b0;
      else if (!arm) pending <= 1'b0;
      else           pending <= (pending & ~clear) | hit;
   end
endmodule

// File: rtl/dma_block_channel.sv
module dma_block_channel #(
   parameter int AW    = 24,
   parameter int DW    = 16,
   parameter int CW    = 16,
   parameter int BW    = 8,
   parameter int NTRIG = 5,
   localparam int SW   = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [AW-1:0]    cfg_src,
   input  logic [AW-1:0]    cfg_dst,
   input  logic [CW-1:0]    cfg_count,
   input  logic [BW-1:0]    cfg_blk,
   input  logic             cfg_block,
   input  logic             cfg_auto,
   input  logic             cfg_burst,
   input  logic             cfg_word,
   input  logic [1:0]       cfg_src_step,
   input  logic [1:0]       cfg_dst_step,
   input  logic             cfg_fix_dst,
   input  logic             cfg_ie,
   input  logic [SW-1:0]    cfg_trig,
   input  logic [NTRIG-1:0] trig_in,
   output logic             bus_req,
   input  logic             bus_gnt,
   output logic             bus_rd,
   output logic             bus_wr,
   output logic             bus_word,
   output logic [AW-1:0]    bus_addr,
   output logic [DW-1:0]    bus_wdata,
   input  logic [DW-1:0]    bus_rdata,
   output logic             busy,
   output logic             irq
);
   import dma_pkg::*;

   if (DW < 16) begin : g_bad_dw
      $error("dma_block_channel: DW must hold a word");
   end
   if (CW < 1 || BW < 1) begin : g_bad_cnt
      $error("dma_block_channel: counter widths must be positive");
   end

   state_e        st, st_nx;
   logic          en_q, blk_q, auto_q, burst_q, word_q, fixdst_q, ie_q, irq_q;
   logic [1:0]    sstep_q, dstep_q;
   logic [SW-1:0] trig_q;
   logic [DW-1:0] data_q;
   logic          accept, pending, start, run_on;
   logic          tc_last, bs_last, blk_end, fin;
   logic [AW-1:0] src_addr, dst_addr;
   logic [CW-1:0] tc_cnt;
   logic [BW-1:0] bs_cnt;

   assign accept  = cfg_we & ~en_q;
   assign run_on  = ~blk_q & auto_q;
   assign start   = (st == ST_IDLE) & en_q & (run_on | pending);
   assign blk_end = (st == ST_WR) & blk_q & bs_last;
   assign fin     = (st == ST_WR) & tc_last & (~blk_q | bs_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0; blk_q <= 1'b0; auto_q <= 1'b0; burst_q <= 1'b0;
         word_q <= 1'b0; fixdst_q <= 1'b0; ie_q <= 1'b0;
         sstep_q <= 2'd0; dstep_q <= 2'd0; trig_q <= '0;
      end else if (accept) begin
         en_q <= 1'b1; blk_q <= cfg_block; auto_q <= cfg_auto;
         burst_q <= cfg_burst; word_q <= cfg_word; fixdst_q <= cfg_fix_dst;
         ie_q <= cfg_ie; sstep_q <= cfg_src_step; dstep_q <= cfg_dst_step;
         trig_q <= cfg_trig;
      end else if (fin) begin
         en_q <= 1'b0;
      end
   end

   always_comb begin
      st_nx = st;
      case (st)
         ST_IDLE: if (start) st_nx = ST_REQ;
         ST_REQ:  if (bus_gnt) st_nx = ST_RD;
         ST_RD:   st_nx = ST_WR;
         ST_WR: begin
            if (fin)                         st_nx = ST_IDLE;
            else if (blk_q && !bs_last)      st_nx = ST_RD;
            else if (!blk_q && auto_q && burst_q) st_nx = ST_RD;
            else                             st_nx = ST_GAP;
         end
         ST_GAP:  st_nx = ST_IDLE;
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         data_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         st    <= st_nx;
         irq_q <= fin & ie_q;
         if (st == ST_RD) data_q <= bus_rdata;
      end
   end

   dma_trig_pick #(.NTRIG(NTRIG)) u_pick (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .sel(trig_q),
      .arm(en_q & ~run_on), .clear(start), .pending(pending)
   );

   dma_addr_unit #(.AW(AW)) u_src (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_val(cfg_src),
      .step(sstep_q), .word(word_q), .adv(st == ST_RD),
      .rewind(blk_end & ~fixdst_q), .addr(src_addr)
   );

   dma_addr_unit #(.AW(AW)) u_dst (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_val(cfg_dst),
      .step(dstep_q), .word(word_q), .adv(st == ST_WR),
      .rewind(blk_end & fixdst_q), .addr(dst_addr)
   );

   dma_dcount #(.W(CW), .RELOAD(1'b0)) u_tc (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_val(cfg_count),
      .dec((st == ST_WR) & (~blk_q | bs_last)), .reload(1'b0),
      .cnt(tc_cnt), .last(tc_last)
   );

   dma_dcount #(.W(BW), .RELOAD(1'b1)) u_bs (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_val(cfg_blk),
      .dec((st == ST_WR) & blk_q & ~bs_last), .reload(blk_end),
      .cnt(bs_cnt), .last(bs_last)
   );

   assign bus_req   = (st == ST_REQ) | (st == ST_RD) | (st == ST_WR);
   assign bus_rd    = (st == ST_RD);
   assign bus_wr    = (st == ST_WR);
   assign bus_word  = word_q;
   assign bus_addr  = (st == ST_WR) ? dst_addr : src_addr;
   assign bus_wdata = data_q;
   assign busy      = en_q;
   assign irq       = irq_q;

   assert_cycle_owns_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd || bus_wr) |-> (bus_req && bus_gnt));
   assert_read_then_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> bus_wr);
   assert_steal_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !blk_q && !(auto_q && burst_q)) |=> !bus_req);
   assert_block_len_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && blk_q) |-> (bs_cnt != '0));
   assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   assert_irq_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (!busy && ie_q));
   assert_cnt_alive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !fin && !blk_q) |=> busy);
endmodule

// File: tb/dma_block_channel_test.sv
`timescale 1ns/1ps
module dma_block_channel_test;
   localparam int AW = 24, DW = 16, CW = 8, BW = 4, NTRIG = 5, SW = 3;
   localparam int LOGN = 1024;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_we = 0, cfg_block = 0, cfg_auto = 0, cfg_burst = 0, cfg_word = 0;
   logic cfg_fix_dst = 0, cfg_ie = 0;
   logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
   logic [CW-1:0] cfg_count = '0;
   logic [BW-1:0] cfg_blk = '0;
   logic [1:0] cfg_src_step = 0, cfg_dst_step = 0;
   logic [SW-1:0] cfg_trig = '0;
   logic [NTRIG-1:0] trig_in = '0;
   logic bus_req, bus_gnt = 1'b0, bus_rd, bus_wr, bus_word, busy, irq;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata, bus_rdata;

   always #2.5 clk = ~clk;

   dma_block_channel #(.AW(AW), .DW(DW), .CW(CW), .BW(BW), .NTRIG(NTRIG)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
      .cfg_count(cfg_count), .cfg_blk(cfg_blk), .cfg_block(cfg_block), .cfg_auto(cfg_auto),
      .cfg_burst(cfg_burst), .cfg_word(cfg_word), .cfg_src_step(cfg_src_step),
      .cfg_dst_step(cfg_dst_step), .cfg_fix_dst(cfg_fix_dst), .cfg_ie(cfg_ie),
      .cfg_trig(cfg_trig), .trig_in(trig_in), .bus_req(bus_req), .bus_gnt(bus_gnt),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_word(bus_word), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .irq(irq)
   );

   function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
      return a[15:0] ^ {a[23:16], a[23:16]} ^ 16'h3C96;
   endfunction

   assign bus_rdata = memf(bus_addr);
   always_ff @(posedge clk) bus_gnt <= bus_req;

   int checks = 0, errors = 0;
   int rd_n = 0, wr_n = 0, rises = 0, irqs = 0;
   logic prev_req = 1'b0;
   logic [AW-1:0] rd_a [LOGN];
   logic [AW-1:0] wr_a [LOGN];
   logic [DW-1:0] wr_d [LOGN];

   always @(negedge clk) begin
      if (bus_rd && rd_n < LOGN) begin rd_a[rd_n] = bus_addr; rd_n++; end
      if (bus_wr && wr_n < LOGN) begin wr_a[wr_n] = bus_addr; wr_d[wr_n] = bus_wdata; wr_n++; end
      if (bus_req && !prev_req) rises++;
      if (irq) irqs++;
      prev_req = bus_req;
   end

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] stepped(input logic [AW-1:0] b, input logic [1:0] s,
                                             input logic w, input int k);
      logic [AW-1:0] d = AW'(k * (w ? 2 : 1));
      if (s == 2'd1) return b + d;
      if (s == 2'd2) return b - d;
      return b;
   endfunction

   task automatic setup(input logic blk, input logic au, input logic bu, input logic w,
                        input logic [1:0] ss, input logic [1:0] ds, input logic fd,
                        input logic ie, input int tr, input logic [AW-1:0] s,
                        input logic [AW-1:0] d, input int cnt, input int b);
      @(negedge clk);
      rd_n = 0; wr_n = 0; rises = 0; irqs = 0;
      cfg_block = blk; cfg_auto = au; cfg_burst = bu; cfg_word = w;
      cfg_src_step = ss; cfg_dst_step = ds; cfg_fix_dst = fd; cfg_ie = ie;
      cfg_trig = SW'(tr); cfg_src = s; cfg_dst = d; cfg_count = CW'(cnt); cfg_blk = BW'(b);
      cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pulse(input int idx);
      @(negedge clk);
      trig_in[idx] = 1'b1;
      @(negedge clk);
      trig_in = '0;
   endtask

   task automatic wait_idle(input string tag);
      int n = 0;
      while (busy && n < 5000) begin @(negedge clk); n++; end
      check(!busy, tag, longint'(busy), 0);
      repeat (3) @(negedge clk);
   endtask

   // Compare logs; b = 0 means normal mode numbering
   task automatic verify(input string tag, input int total, input int b, input logic fd,
                         input logic w, input logic [1:0] ss, input logic [1:0] ds,
                         input logic [AW-1:0] s0, input logic [AW-1:0] d0);
      int bad = 0, first = -1;
      logic [AW-1:0] es = '0, ed = '0, fs = '0, fdd = '0;
      for (int i = 0; i < total; i++) begin
         int si = i, di = i;
         if (b > 0) begin
            if (fd) di = i % b; else si = i % b;
         end
         es = stepped(s0, ss, w, si);
         ed = stepped(d0, ds, w, di);
         if (i >= wr_n || rd_a[i] !== es || wr_a[i] !== ed || wr_d[i] !== memf(es)) begin
            bad++;
            if (first < 0) begin first = i; fs = es; fdd = ed; end
         end
      end
      check(wr_n == total, {tag, " unit count"}, wr_n, total);
      if (first >= 0)
         check(1'b0, {tag, " addresses"}, longint'(first < wr_n ? wr_a[first] : '0), longint'(fdd));
      else
         check(1'b1, {tag, " addresses"}, 0, 0);
      if (first >= 0) $display("  first bad unit %0d, expected source %0h", first, fs);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check({bus_req, bus_rd, bus_wr, busy, irq} == 5'b0, "R1 reset outputs",
            longint'({bus_req, bus_rd, bus_wr, busy, irq}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check({bus_req, busy, irq} == 3'b0, "R1 idle after reset", longint'({bus_req, busy, irq}), 0);

      // R4 R2 R3: burst auto, byte increment both sides
      setup(0, 1, 1, 0, 2'd1, 2'd1, 0, 1, 0, 24'h001000, 24'h002000, 5, 1);
      wait_idle("R4 burst end");
      verify("R2 R3 burst bytes", 5, 0, 0, 0, 2'd1, 2'd1, 24'h001000, 24'h002000);
      check(rises == 1, "R4 bus held for burst", rises, 1);
      check(irqs == 1, "R10 irq pulse", irqs, 1);

      // R5 R3: cycle steal, word, source decrements through zero
      setup(0, 1, 0, 1, 2'd2, 2'd1, 0, 1, 0, 24'h000002, 24'h7FFFF0, 4, 1);
      wait_idle("R5 steal end");
      verify("R3 word decrement wrap", 4, 0, 0, 1, 2'd2, 2'd1, 24'h000002, 24'h7FFFF0);
      check(rises == 4, "R5 bus released per unit", rises, 4);

      // R3 R10: fixed source, irq disabled
      setup(0, 1, 1, 1, 2'd0, 2'd2, 0, 0, 0, 24'hABCDEE, 24'h000100, 3, 1);
      wait_idle("R10 end no irq");
      verify("R3 fixed source", 3, 0, 0, 1, 2'd0, 2'd2, 24'hABCDEE, 24'h000100);
      check(irqs == 0, "R10 irq masked", irqs, 0);

      // R7: count zero means 2^CW transfers
      setup(0, 1, 1, 0, 2'd1, 2'd1, 0, 1, 0, 24'h010000, 24'h020000, 0, 1);
      wait_idle("R7 full count end");
      verify("R7 count zero", 1 << CW, 0, 0, 0, 2'd1, 2'd1, 24'h010000, 24'h020000);

      // R6: external request, one unit per pulse
      setup(0, 0, 0, 0, 2'd1, 2'd1, 0, 1, 4, 24'h003000, 24'h004000, 3, 1);
      repeat (10) @(negedge clk);
      check(wr_n == 0, "R6 no move without request", wr_n, 0);
      pulse(4); repeat (12) @(negedge clk);
      pulse(4); repeat (12) @(negedge clk);
      check(wr_n == 2 && busy, "R6 one unit per pulse", wr_n, 2);
      pulse(2); repeat (12) @(negedge clk);
      check(wr_n == 2, "R6 other line ignored", wr_n, 2);
      pulse(4);
      wait_idle("R6 end");
      verify("R6 ext units", 3, 0, 0, 0, 2'd1, 2'd1, 24'h003000, 24'h004000);
      check(irqs == 1, "R10 irq after ext run", irqs, 1);

      // R8 R9: block sweep
      for (int bi = 0; bi < 4; bi++) begin
         for (int f = 0; f < 2; f++) begin
            int b = (bi == 3) ? 15 : bi + 1;
            int sel = (bi * 2 + f) % NTRIG;
            int oth = (sel + 1) % NTRIG;
            logic w = bi[0];
            logic [1:0] ds = f ? 2'd1 : 2'd2;
            logic [AW-1:0] s0 = AW'(24'h100000 + bi * 24'h400);
            logic [AW-1:0] d0 = AW'(24'h200000 + f * 24'h800);
            setup(1, 0, 0, w, 2'd1, ds, logic'(f), 1, sel, s0, d0, 3, b);
            for (int j = 0; j < 3; j++) begin
               pulse(oth); repeat (8) @(negedge clk);
               check(wr_n == j * b, "R8 unselected line ignored", wr_n, j * b);
               pulse(sel);
               repeat (2 * b + 10) @(negedge clk);
               check(wr_n == (j + 1) * b, "R8 units per block", wr_n, (j + 1) * b);
               check(rises == j + 1, "R8 bus held within block", rises, j + 1);
            end
            wait_idle("R8 block run end");
            verify("R9 block addresses", 3 * b, b, logic'(f), w, 2'd1, ds, s0, d0);
            check(irqs == 1, "R10 block irq", irqs, 1);
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule